// File: doc/BRIEF.md
# Power Supply Supervisor Sequencer

This block is the digital core of a supervisor for a three-rail switch-mode power supply. Analog comparators, which are outside the block, report each rail's state as single-bit flags: over-voltage and under-voltage per rail, an "auxiliary level good" flag for a user-defined check, a power-good qualifier from elsewhere in the system, and a remote request that commands the supply off.

The block drives two outputs. `fault` turns the main PWM stage off while it is high. `pg_out` tells the load that the supply is usable. A fault latch records trips from two paths:

- The over-voltage path is ORed with the auxiliary flag being low, and short spikes on it are filtered out.
- The under-voltage path is masked for a blanking window after power-up.

Only a remote-off request held past its debounce time clears the latch. `pg_out` follows the healthy condition after a hold-off delay and drops as soon as that condition is lost.

All delays are counted in clock cycles and set by parameters. Every input flag passes through a two-flop synchronizer before any logic uses it.

Top module: `supply_supervisor`

## Requirements
- R1: A rail over-voltage flag, a rail under-voltage flag, or `adj_ok` low sets the fault latch, subject to the filter in R2 and the blanking in R3. Once set, `fault` stays high after the condition goes away.
- R2: The OR of any `ov_flag` bit with `adj_ok` low must hold for more than `OV_DELAY` consecutive synchronized cycles before the latch sets. A pulse of `OV_DELAY` cycles or fewer is ignored.
- R3: Under-voltage flags are ignored for `UV_BLANK` cycles after reset is released. The same window restarts when the debounced remote request returns to on.
- R4: While the synchronized `remote_off` is high, `fault` is high and `pg_out` is low.
- R5: The fault latch clears only when `remote_off` is held high for at least `REM_DELAY` synchronized cycles. A shorter pulse leaves the latch set. The debounced remote state also changes back to on only after `remote_off` has stayed low for `REM_DELAY` cycles.
- R6: `pg_out` rises `PG_DELAY`+1 cycles after its qualifier becomes true. The qualifier is all of the following: remote on (both synchronized and debounced), `pg_in` high, `adj_ok` high, every rail flag clear, and the latch clear. `pg_out` falls one cycle after the synchronized qualifier drops. The delay count restarts from zero every time the qualifier returns.
- R7: `pg_in` low holds `pg_out` low even with all rails good, and `pg_in` has no effect on `fault`.
- R8: During reset `fault` is high and `pg_out` is low.
- R9: Every input flag reaches the logic through two synchronizer flops. No output reacts within one clock edge of an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_flag | input | NRAIL | Per-rail over-voltage comparator flags |
| uv_flag | input | NRAIL | Per-rail under-voltage comparator flags |
| adj_ok | input | 1 | Auxiliary level good; low counts as a fault condition |
| pg_in | input | 1 | External power-good qualifier |
| remote_off | input | 1 | High requests the supply off; also clears the latch |
| fault | output | 1 | High disables the main PWM |
| pg_out | output | 1 | Power good |

## Verification
The bench builds the block with `OV_DELAY`=4, `UV_BLANK`=12, `REM_DELAY`=5 and `PG_DELAY`=10. These values put every timer boundary within a few dozen cycles, so the bench can probe each one exactly at its edge:

- an over-voltage pulse one cycle too short and one that is long enough;
- a remote pulse of `REM_DELAY`-1 cycles and one of `REM_DELAY` cycles;
- the last blanked cycle and the first unblanked one, both after reset and after a remote cycle;
- the cycle just before `pg_out` rises.

The small delays also leave room to run a full input-combination table, with a latch clear before each entry.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef struct packed {
        logic latch;
        logic fault;
        logic pg;
    } supv_state_t;

    localparam supv_state_t SUPV_RESET = '{latch: 1'b0, fault: 1'b1, pg: 1'b0};

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int               W       = 1,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d_in;
            s2_q <= s1_q;
        end
    end

    assign d_out = s2_q;
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)              cnt_d = '0;
        else if (cnt_q == LIM) cnt_d = cnt_q;
        else                  cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == LIM);

    // R2: the saturating count never passes its limit
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);
endmodule

// File: rtl/supv_debounce.sv
module supv_debounce #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in,
    output logic out
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          out_d, out_q;

    always_comb begin
        out_d = out_q;
        cnt_d = '0;
        if (in != out_q) begin
            if (cnt_q == LAST) out_d = in;
            else               cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            out_q <= out_d;
        end
    end

    assign out = out_q;

    // R5: the debounced state only moves after a full run of differing samples
    a_r5_debounce_run: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> ($past(cnt_q) == LAST && $past(in) == out_q));
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
    parameter int NRAIL     = 3,
    parameter int OV_DELAY  = 5_000_000,
    parameter int UV_BLANK  = 15_000_000,
    parameter int REM_DELAY = 2_250_000,
    parameter int PG_DELAY  = 15_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NRAIL-1:0] ov_flag,
    input  logic [NRAIL-1:0] uv_flag,
    input  logic             adj_ok,
    input  logic             pg_in,
    input  logic             remote_off,
    output logic             fault,
    output logic             pg_out
);
    import supv_pkg::*;

    localparam int SW = 2 * NRAIL + 3;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b0, 1'b1, {(2*NRAIL){1'b0}}};

    logic [SW-1:0]    raw_in, syn;
    logic [NRAIL-1:0] ov_s, uv_s;
    logic             adj_s, pgi_s, rem_s, rem_db;
    logic             ov_cond, ov_done, blank_done, pg_qual, pg_done;
    logic             ov_trip, uv_trip;
    supv_state_t      st_d, st_q;

    assign raw_in = {remote_off, pg_in, adj_ok, uv_flag, ov_flag};

    supv_sync #(.W(SW), .RST_VAL(SYNC_RST)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_in(raw_in), .d_out(syn)
    );

    assign ov_s  = syn[NRAIL-1:0];
    assign uv_s  = syn[2*NRAIL-1:NRAIL];
    assign adj_s = syn[2*NRAIL];
    assign pgi_s = syn[2*NRAIL+1];
    assign rem_s = syn[2*NRAIL+2];

    supv_debounce #(.LIMIT(REM_DELAY)) i_rem_db (
        .clk(clk), .rst_n(rst_n), .in(rem_s), .out(rem_db)
    );

    // spike filter on the over-voltage / auxiliary path
    assign ov_cond = (|ov_s) | ~adj_s;

    supv_hold_timer #(.LIMIT(OV_DELAY)) i_ov_filt (
        .clk(clk), .rst_n(rst_n), .clr(~ov_cond), .done(ov_done)
    );

    // under-voltage blanking window, held at zero while remote is off
    supv_hold_timer #(.LIMIT(UV_BLANK)) i_uv_blank (
        .clk(clk), .rst_n(rst_n), .clr(rem_db), .done(blank_done)
    );

    assign ov_trip = ov_cond & ov_done;
    assign uv_trip = (|uv_s) & blank_done;

    supv_hold_timer #(.LIMIT(PG_DELAY)) i_pg_delay (
        .clk(clk), .rst_n(rst_n), .clr(~pg_qual), .done(pg_done)
    );

    always_comb begin
        st_d = st_q;
        st_d.latch = rem_db ? 1'b0 : (st_q.latch | ov_trip | uv_trip);
        pg_qual = ~rem_s & ~rem_db & pgi_s & adj_s & ~(|ov_s) & ~(|uv_s)
                  & ~st_d.latch;
        st_d.fault = st_d.latch | rem_s;
        st_d.pg    = pg_qual & pg_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SUPV_RESET;
        else        st_q <= st_d;
    end

    assign fault  = st_q.fault;
    assign pg_out = st_q.pg;

    // R4: a synchronized remote-off request forces the outputs
    a_r4_remote_forces: assert property (@(posedge clk) disable iff (!rst_n)
        rem_s |=> (st_q.fault && !st_q.pg));

    // R5: only the debounced remote request releases the latch
    a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latch && !rem_db) |=> st_q.latch);

    // R6: power good and fault are never asserted together
    a_r6_pg_excludes_fault: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pg |-> !st_q.fault);

    // R1: a set latch always shows on the fault output
    a_r1_latch_visible: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.latch |-> st_q.fault);
endmodule

// File: tb/test_supply_supervisor.sv
module test_supply_supervisor;
    localparam int PERIOD    = 10;
    localparam int OV_DELAY  = 4;
    localparam int UV_BLANK  = 12;
    localparam int REM_DELAY = 5;
    localparam int PG_DELAY  = 10;

    // {ov[2:0], uv[2:0], adj, pgi, remote, exp_fault, exp_pg}
    localparam int NVEC = 10;
    localparam logic [10:0] VEC [NVEC] = '{
        11'b000_000_1_1_0_0_1,
        11'b000_000_1_0_0_0_0,
        11'b001_000_1_1_0_1_0,
        11'b100_000_1_1_0_1_0,
        11'b000_010_1_1_0_1_0,
        11'b000_000_0_1_0_1_0,
        11'b000_000_1_1_1_1_0,
        11'b000_100_1_0_0_1_0,
        11'b010_000_1_0_0_1_0,
        11'b000_000_0_0_1_1_0
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] ov_flag, uv_flag;
    logic       adj_ok, pg_in, remote_off;
    logic       fault, pg_out;
    int         checks = 0;
    int         fails  = 0;

    always #(PERIOD / 2) clk = ~clk;

    supply_supervisor #(
        .NRAIL(3), .OV_DELAY(OV_DELAY), .UV_BLANK(UV_BLANK),
        .REM_DELAY(REM_DELAY), .PG_DELAY(PG_DELAY)
    ) i_supply_supervisor (
        .clk(clk), .rst_n(rst_n), .ov_flag(ov_flag), .uv_flag(uv_flag),
        .adj_ok(adj_ok), .pg_in(pg_in), .remote_off(remote_off),
        .fault(fault), .pg_out(pg_out)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic good_inputs();
        ov_flag = '0; uv_flag = '0; adj_ok = 1'b1; pg_in = 1'b1;
    endtask

    task automatic clear_latch();
        good_inputs();
        remote_off = 1'b1;
        cyc(REM_DELAY + 4);
        remote_off = 1'b0;
        cyc(REM_DELAY + UV_BLANK + PG_DELAY + 12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        good_inputs();
        uv_flag = 3'b001;
        remote_off = 1'b0;
        cyc(3);
        chk("R8 fault in reset", fault, 1'b1);
        chk("R8 pg in reset", pg_out, 1'b0);
        rst_n = 1'b1;
        cyc(UV_BLANK - 1);
        chk("R3 uv blanked after reset", fault, 1'b0);
        cyc(4);
        chk("R3 uv seen after blanking", fault, 1'b1);
        clear_latch();
        chk("R5 latch cleared by remote", fault, 1'b0);
        chk("R6 pg up with good inputs", pg_out, 1'b1);

        // function table
        for (int v = 0; v < NVEC; v++) begin
            clear_latch();
            ov_flag    = VEC[v][10:8];
            uv_flag    = VEC[v][7:5];
            adj_ok     = VEC[v][4];
            pg_in      = VEC[v][3];
            remote_off = VEC[v][2];
            cyc(40);
            chk($sformatf("R1 R4 R7 vector %0d fault", v), fault, VEC[v][1]);
            chk($sformatf("R4 R6 R7 vector %0d pg", v), pg_out, VEC[v][0]);
        end

        // synchronizer latency and forced fault
        clear_latch();
        remote_off = 1'b1;
        cyc(1);
        chk("R9 no reaction after one edge", fault, 1'b0);
        cyc(1);
        chk("R9 no reaction after two edges", fault, 1'b0);
        cyc(1);
        chk("R4 remote forces fault", fault, 1'b1);
        chk("R4 remote forces pg low", pg_out, 1'b0);

        // over-voltage spike filter
        clear_latch();
        ov_flag = 3'b010;
        cyc(OV_DELAY);
        ov_flag = '0;
        cyc(20);
        chk("R2 short ov spike ignored", fault, 1'b0);
        ov_flag = 3'b010;
        cyc(OV_DELAY + 2);
        ov_flag = '0;
        cyc(20);
        chk("R2 R1 long ov latched", fault, 1'b1);

        // remote pulse width
        remote_off = 1'b1;
        cyc(REM_DELAY - 1);
        remote_off = 1'b0;
        cyc(20);
        chk("R5 short remote pulse keeps latch", fault, 1'b1);
        remote_off = 1'b1;
        cyc(REM_DELAY);
        remote_off = 1'b0;
        cyc(25);
        chk("R5 full remote pulse clears latch", fault, 1'b0);

        // auxiliary path
        adj_ok = 1'b0;
        cyc(OV_DELAY + 2);
        adj_ok = 1'b1;
        cyc(20);
        chk("R1 adj low latched", fault, 1'b1);
        chk("R6 pg low while latched", pg_out, 1'b0);

        // blanking restarts after remote on
        good_inputs();
        remote_off = 1'b1;
        cyc(REM_DELAY + 4);
        remote_off = 1'b0;
        uv_flag = 3'b001;
        cyc(REM_DELAY + UV_BLANK + 1);
        chk("R3 uv blanked after remote on", fault, 1'b0);
        cyc(4);
        chk("R3 uv seen after remote blanking", fault, 1'b1);

        // power-good drop and restart
        clear_latch();
        pg_in = 1'b0;
        cyc(3);
        chk("R6 pg drops promptly", pg_out, 1'b0);
        chk("R7 pg_in no effect on fault", fault, 1'b0);
        cyc(2);
        pg_in = 1'b1;
        cyc(PG_DELAY + 2);
        chk("R6 pg delay restarted", pg_out, 1'b0);
        cyc(2);
        chk("R6 pg up after delay", pg_out, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule